// File: doc/BRIEF.md
# Banked General Register File

This block holds sixteen general-purpose 32-bit registers for a processor core. Logical registers 0 to 7 are backed by two physical copies (bank 0 and bank 1), and a registered bank-select decides which copy normal accesses reach. Registers 8 to 15 exist once and are shared by both bank settings. Two combinational read ports and one synchronous write port serve the execution pipeline.

A separate transfer port, addressed 0 to 7, reaches the bank that is currently hidden. Save/restore code uses it to move data between banks without switching banks. The transfer port is honoured only when the privilege input is high. The bank-select register resets to bank 1, so code that starts after reset runs on bank 1. Exception sequencing, the status register and instruction decode lie outside the block, which only consumes the select and privilege inputs.

Top module: `bank_rf`

## Requirements
- R1: A normal write or read of register 0–7 reaches bank 1 when the internal bank register is 1, and bank 0 when it is 0.
- R2: Registers 8–15 are a single set: a value written under either bank setting reads back the same under the other setting.
- R3: With priv_i high, the transfer port (address 0–7) writes and reads the bank opposite to the one normal accesses use.
- R4: The internal bank register is 1 while reset is asserted and in the first cycle after release, whatever bank_sel_i is.
- R5: bank_sel_i is registered: accesses in the cycle in which it changes still use the old bank, and accesses from the next cycle on use the new one.
- R6: With priv_i low, a transfer-port write leaves every register unchanged.
- R7: With priv_i low, xfer_rdata_o is zero.
- R8: A read port whose address matches a same-cycle write to the same physical register returns the write data in that cycle (write-first). This applies to the transfer port as well.
- R9: A normal write and a privileged transfer write to the same low address in one cycle both take effect, each in its own bank.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset (bank register only) |
| bank_sel_i | input | 1 | Requested bank for registers 0–7 |
| priv_i | input | 1 | Privileged mode; enables the transfer port |
| rd_a_addr_i | input | 4 | Read port A address |
| rd_a_data_o | output | 32 | Read port A data |
| rd_b_addr_i | input | 4 | Read port B address |
| rd_b_data_o | output | 32 | Read port B data |
| wr_en_i | input | 1 | Normal write enable |
| wr_addr_i | input | 4 | Normal write address |
| wr_data_i | input | 32 | Normal write data |
| xfer_we_i | input | 1 | Transfer-port write enable |
| xfer_addr_i | input | 3 | Transfer-port address (0–7) |
| xfer_wdata_i | input | 32 | Transfer-port write data |
| xfer_rdata_o | output | 32 | Transfer-port read data (hidden bank) |

## Verification
The bench uses the default parameters: 32-bit data, eight banked and eight shared registers. At these values the full 4-bit address space is covered, including the boundary between register 7 (banked) and register 8 (shared), and every transfer address maps onto a real hidden-bank entry. The directed tasks check both reset-time bank selection and the one-cycle lag of bank switching at the ports. They also check the write-first bypass on all three read paths and the case where both write ports hit one low address in the same cycle.

// File: rtl/bank_rf_pkg.sv
package bank_rf_pkg;
  typedef enum logic {
    BANK0 = 1'b0,
    BANK1 = 1'b1
  } bank_e;

  localparam bank_e BANK_AT_RESET = BANK1;

  function automatic bank_e hidden_bank(input bank_e b);
    return (b == BANK1) ? BANK0 : BANK1;
  endfunction
endpackage

// File: rtl/rf_store.sv
module rf_store #(
  parameter int unsigned DEPTH = 8,
  parameter int unsigned W     = 32
) (
  input  logic                       clk_i,
  input  logic                       we_i,
  input  logic [$clog2(DEPTH)-1:0]   waddr_i,
  input  logic [W-1:0]               wdata_i,
  output logic [DEPTH-1:0][W-1:0]    mem_o
);
  // storage has no reset by design
  logic [DEPTH-1:0][W-1:0] mem_q;

  always_ff @(posedge clk_i) begin
    if (we_i) mem_q[waddr_i] <= wdata_i;
  end

  assign mem_o = mem_q;
endmodule

// File: rtl/rf_read_port.sv
module rf_read_port #(
  parameter int unsigned W      = 32,
  parameter int unsigned N_LOW  = 8,
  parameter int unsigned N_HIGH = 8,
  localparam int unsigned AW     = $clog2(N_LOW + N_HIGH),
  localparam int unsigned LOW_AW = $clog2(N_LOW),
  localparam int unsigned HI_AW  = $clog2(N_HIGH)
) (
  input  logic [AW-1:0]               addr_i,
  input  logic                        bank_i,
  input  logic [N_LOW-1:0][W-1:0]     low0_i,
  input  logic [N_LOW-1:0][W-1:0]     low1_i,
  input  logic [N_HIGH-1:0][W-1:0]    high_i,
  input  logic                        byp_en_i,
  input  logic [W-1:0]                byp_data_i,
  output logic [W-1:0]                rdata_o
);
  logic [AW-1:0]     hi_off;
  logic [LOW_AW-1:0] low_idx;
  logic [HI_AW-1:0]  hi_idx;

  assign hi_off  = addr_i - AW'(N_LOW);
  assign hi_idx  = hi_off[HI_AW-1:0];
  assign low_idx = addr_i[LOW_AW-1:0];

  always_comb begin
    if (byp_en_i)                  rdata_o = byp_data_i;
    else if (addr_i < AW'(N_LOW))  rdata_o = bank_i ? low1_i[low_idx] : low0_i[low_idx];
    else                           rdata_o = high_i[hi_idx];
  end
endmodule

// File: rtl/bank_rf.sv
module bank_rf
  import bank_rf_pkg::*;
#(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned N_LOW  = 8,
  parameter int unsigned N_HIGH = 8,
  localparam int unsigned AW     = $clog2(N_LOW + N_HIGH),
  localparam int unsigned LOW_AW = $clog2(N_LOW),
  localparam int unsigned HI_AW  = $clog2(N_HIGH)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              bank_sel_i,
  input  logic              priv_i,
  input  logic [AW-1:0]     rd_a_addr_i,
  output logic [DATA_W-1:0] rd_a_data_o,
  input  logic [AW-1:0]     rd_b_addr_i,
  output logic [DATA_W-1:0] rd_b_data_o,
  input  logic              wr_en_i,
  input  logic [AW-1:0]     wr_addr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic              xfer_we_i,
  input  logic [LOW_AW-1:0] xfer_addr_i,
  input  logic [DATA_W-1:0] xfer_wdata_i,
  output logic [DATA_W-1:0] xfer_rdata_o
);
  bank_e bank_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) bank_q <= BANK_AT_RESET;
    else         bank_q <= bank_e'(bank_sel_i);
  end

  logic             bank_act;
  logic             bank_hid;
  logic             wr_is_low;
  logic             xfer_ok;
  logic [AW-1:0]    wr_hi_off;
  logic [HI_AW-1:0] wr_hi_idx;

  assign bank_act  = bank_q;
  assign bank_hid  = hidden_bank(bank_q);
  assign wr_is_low = wr_addr_i < AW'(N_LOW);
  assign xfer_ok   = xfer_we_i & priv_i;
  assign wr_hi_off = wr_addr_i - AW'(N_LOW);
  assign wr_hi_idx = wr_hi_off[HI_AW-1:0];

  logic [N_LOW-1:0][DATA_W-1:0]  low_mem [2];
  logic [N_HIGH-1:0][DATA_W-1:0] high_mem;

  // two physical copies of the low registers
  for (genvar g = 0; g < 2; g++) begin : g_low_bank
    logic              we;
    logic [LOW_AW-1:0] waddr;
    logic [DATA_W-1:0] wdata;
    logic              norm_hit;

    assign norm_hit = wr_en_i & wr_is_low & (bank_act == 1'(g));
    assign we       = norm_hit | (xfer_ok & (bank_hid == 1'(g)));
    assign waddr    = norm_hit ? wr_addr_i[LOW_AW-1:0] : xfer_addr_i;
    assign wdata    = norm_hit ? wr_data_i : xfer_wdata_i;

    rf_store #(.DEPTH(N_LOW), .W(DATA_W)) u_store (
      .clk_i   (clk_i),
      .we_i    (we),
      .waddr_i (waddr),
      .wdata_i (wdata),
      .mem_o   (low_mem[g])
    );
  end

  rf_store #(.DEPTH(N_HIGH), .W(DATA_W)) u_high (
    .clk_i   (clk_i),
    .we_i    (wr_en_i & ~wr_is_low),
    .waddr_i (wr_hi_idx),
    .wdata_i (wr_data_i),
    .mem_o   (high_mem)
  );

  // normal reads share bank with normal write, so address match means same physical reg
  rf_read_port #(.W(DATA_W), .N_LOW(N_LOW), .N_HIGH(N_HIGH)) u_rd_a (
    .addr_i     (rd_a_addr_i),
    .bank_i     (bank_act),
    .low0_i     (low_mem[0]),
    .low1_i     (low_mem[1]),
    .high_i     (high_mem),
    .byp_en_i   (wr_en_i && (wr_addr_i == rd_a_addr_i)),
    .byp_data_i (wr_data_i),
    .rdata_o    (rd_a_data_o)
  );

  rf_read_port #(.W(DATA_W), .N_LOW(N_LOW), .N_HIGH(N_HIGH)) u_rd_b (
    .addr_i     (rd_b_addr_i),
    .bank_i     (bank_act),
    .low0_i     (low_mem[0]),
    .low1_i     (low_mem[1]),
    .high_i     (high_mem),
    .byp_en_i   (wr_en_i && (wr_addr_i == rd_b_addr_i)),
    .byp_data_i (wr_data_i),
    .rdata_o    (rd_b_data_o)
  );

  logic [DATA_W-1:0] xfer_raw;

  rf_read_port #(.W(DATA_W), .N_LOW(N_LOW), .N_HIGH(N_HIGH)) u_rd_x (
    .addr_i     (AW'(xfer_addr_i)),
    .bank_i     (bank_hid),
    .low0_i     (low_mem[0]),
    .low1_i     (low_mem[1]),
    .high_i     (high_mem),
    .byp_en_i   (xfer_ok),
    .byp_data_i (xfer_wdata_i),
    .rdata_o    (xfer_raw)
  );

  assign xfer_rdata_o = priv_i ? xfer_raw : '0;

  AST_RESET_BANK1: assert property (@(posedge clk_i)
    !rst_ni |=> bank_q == BANK1);  // R4

  AST_SEL_TO_BANK1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bank_sel_i |=> bank_q == BANK1);  // R5

  AST_SEL_TO_BANK0: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !bank_sel_i |=> bank_q == BANK0);  // R5

  AST_LOW_WRITE_ACTIVE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && wr_is_low) |=>
      low_mem[$past(bank_q)][$past(wr_addr_i[LOW_AW-1:0])] == $past(wr_data_i));  // R1

  AST_HIGH_WRITE_SHARED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && !wr_is_low) |=> high_mem[$past(wr_hi_idx)] == $past(wr_data_i));  // R2

  AST_XFER_WRITE_HIDDEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (xfer_we_i && priv_i) |=>
      low_mem[!$past(bank_q)][$past(xfer_addr_i)] == $past(xfer_wdata_i));  // R3

  AST_USER_XFER_NO_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!wr_en_i && !priv_i) |=> $stable(low_mem[0]) && $stable(low_mem[1]));  // R6

  AST_USER_XFER_READ_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !priv_i |-> xfer_rdata_o == '0);  // R7

  AST_BYPASS_PORT_A: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && wr_addr_i == rd_a_addr_i) |-> rd_a_data_o == wr_data_i);  // R8
endmodule

// File: tb/bank_rf_bench.sv
`timescale 1ns/1ps
module bank_rf_bench;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        bank_sel_i = 1'b0;
  logic        priv_i = 1'b1;
  logic [3:0]  rd_a_addr_i = '0;
  logic [31:0] rd_a_data_o;
  logic [3:0]  rd_b_addr_i = '0;
  logic [31:0] rd_b_data_o;
  logic        wr_en_i = 1'b0;
  logic [3:0]  wr_addr_i = '0;
  logic [31:0] wr_data_i = '0;
  logic        xfer_we_i = 1'b0;
  logic [2:0]  xfer_addr_i = '0;
  logic [31:0] xfer_wdata_i = '0;
  logic [31:0] xfer_rdata_o;

  int n_vec = 0;
  int n_bad = 0;

  always #2.5 clk_i = ~clk_i;

  bank_rf u_bank_rf (
    .clk_i, .rst_ni, .bank_sel_i, .priv_i,
    .rd_a_addr_i, .rd_a_data_o, .rd_b_addr_i, .rd_b_data_o,
    .wr_en_i, .wr_addr_i, .wr_data_i,
    .xfer_we_i, .xfer_addr_i, .xfer_wdata_i, .xfer_rdata_o
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  // advance one edge, then settle away from it
  task automatic tick();
    @(posedge clk_i);
    #1;
  endtask

  task automatic idle();
    wr_en_i = 1'b0;
    xfer_we_i = 1'b0;
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    wr_en_i = 1'b1; wr_addr_i = a; wr_data_i = d;
    tick();
    idle();
  endtask

  task automatic xwr(input logic [2:0] a, input logic [31:0] d);
    xfer_we_i = 1'b1; xfer_addr_i = a; xfer_wdata_i = d;
    tick();
    idle();
  endtask

  task automatic rd_a(input logic [3:0] a, input logic [31:0] exp, input string tag);
    rd_a_addr_i = a; #0.5;
    chk(tag, rd_a_data_o, exp);
  endtask

  task automatic rd_x(input logic [2:0] a, input logic [31:0] exp, input string tag);
    xfer_addr_i = a; #0.5;
    chk(tag, xfer_rdata_o, exp);
  endtask

  // select held at 0 through reset; first write after release must still land in bank 1
  task automatic t_reset_bank();
    bank_sel_i = 1'b0;
    rst_ni = 1'b0;
    tick(); tick();
    rst_ni = 1'b1;
    wr_en_i = 1'b1; wr_addr_i = 4'd2; wr_data_i = 32'hAAAA_0002;
    xfer_we_i = 1'b1; xfer_addr_i = 3'd2; xfer_wdata_i = 32'hBBBB_0002;
    tick();
    idle();
    rd_a(4'd2, 32'hBBBB_0002, "R4 bank0 after first edge holds xfer data");
    rd_x(3'd2, 32'hAAAA_0002, "R4 normal write at reset went to bank1");
  endtask

  task automatic t_bank_switch();
    wr(4'd3, 32'h0000_3000);       // bank 0
    xwr(3'd3, 32'h1111_3000);      // bank 1
    bank_sel_i = 1'b1;
    rd_a(4'd3, 32'h0000_3000, "R5 same cycle still old bank");
    tick();
    rd_a(4'd3, 32'h1111_3000, "R1 bank1 active reads bank1");
    rd_x(3'd3, 32'h0000_3000, "R3 xfer reads hidden bank0");
    wr(4'd3, 32'h1111_3001);
    bank_sel_i = 1'b0;
    tick();
    rd_x(3'd3, 32'h1111_3001, "R1 write under bank1 landed in bank1");
    rd_a(4'd3, 32'h0000_3000, "R1 bank0 untouched by bank1 write");
  endtask

  task automatic t_shared();
    wr(4'd8, 32'h8888_0008);
    wr(4'd15, 32'hFFFF_000F);
    bank_sel_i = 1'b1;
    tick();
    rd_a(4'd8, 32'h8888_0008, "R2 r8 shared across banks");
    rd_b_addr_i = 4'd15; #0.5;
    chk("R2 r15 shared on port B", rd_b_data_o, 32'hFFFF_000F);
    wr(4'd7, 32'h7777_1007);       // bank 1, last banked
    bank_sel_i = 1'b0;
    tick();
    wr(4'd7, 32'h7777_0007);
    rd_a(4'd7, 32'h7777_0007, "R1 r7 bank0");
    rd_x(3'd7, 32'h7777_1007, "R3 r7 hidden bank1");
  endtask

  task automatic t_user();
    xwr(3'd5, 32'h5555_1005);      // priv: bank 1
    priv_i = 1'b0;
    xfer_we_i = 1'b1; xfer_addr_i = 3'd5; xfer_wdata_i = 32'hDEAD_BEEF; #0.5;
    chk("R7 user xfer read zero", xfer_rdata_o, 32'h0);
    tick();
    idle();
    priv_i = 1'b1;
    rd_x(3'd5, 32'h5555_1005, "R6 user xfer write ignored");
  endtask

  task automatic t_bypass();
    wr(4'd4, 32'h4444_0000);
    wr(4'd9, 32'h9999_0000);
    wr_en_i = 1'b1; wr_addr_i = 4'd4; wr_data_i = 32'h4444_0001;
    rd_a_addr_i = 4'd4; rd_b_addr_i = 4'd9; #0.5;
    chk("R8 port A write-first", rd_a_data_o, 32'h4444_0001);
    chk("R8 port B unrelated old", rd_b_data_o, 32'h9999_0000);
    tick();
    wr_en_i = 1'b1; wr_addr_i = 4'd9; wr_data_i = 32'h9999_0001; #0.5;
    chk("R8 port B write-first high", rd_b_data_o, 32'h9999_0001);
    tick();
    idle();
    xfer_we_i = 1'b1; xfer_addr_i = 3'd1; xfer_wdata_i = 32'h1010_0101; #0.5;
    chk("R8 xfer write-first", xfer_rdata_o, 32'h1010_0101);
    tick();
    idle();
  endtask

  task automatic t_dual();
    wr_en_i = 1'b1; wr_addr_i = 4'd6; wr_data_i = 32'h6666_0000;
    xfer_we_i = 1'b1; xfer_addr_i = 3'd6; xfer_wdata_i = 32'h6666_1111;
    tick();
    idle();
    rd_a(4'd6, 32'h6666_0000, "R9 normal half of dual write");
    rd_x(3'd6, 32'h6666_1111, "R9 xfer half of dual write");
  endtask

  initial begin
    #100000;
    n_bad++;
    $display("FAIL watchdog act=timeout exp=done");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    #1;
    t_reset_bank();
    t_bank_switch();
    t_shared();
    t_user();
    t_bypass();
    t_dual();
    tick();
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule